// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. The memory is driven through three active-low strobes: chip select, output enable and write enable. The host issues one access at a time over a request/ready handshake. It supplies a 15-bit word address, a direction bit and, for writes, a byte of data. The controller answers each access with a single-cycle ready pulse, and for a read that pulse carries the captured byte. On the memory side the data bus is split into an output value, an output-enable for the controller's own driver and an input value, so a pad ring can build the shared bus from them.

Each timing figure of the memory is a parameter in picoseconds, as is the clock period. A phase lasts the smallest whole number of clock cycles that covers its figure, and never less than one cycle. Reads are controlled by output enable: chip select and output enable fall together, and the byte is captured at the end of the access phase. Writes are controlled by write enable: the address and data are set up one cycle before write enable falls and are held one or more cycles after it rises. After a read, output enable stays high long enough for the memory to release the bus before the controller drives it.

The state machine has six states:
- `ST_IDLE`: all strobes are high.
- `ST_RD_ACC`: chip select and output enable are low.
- `ST_RD_REC`: the bus is released.
- `ST_WR_SET`: address and data are presented with chip select low.
- `ST_WR_PULSE`: write enable is low.
- `ST_WR_HOLD`: write enable is high again while data and chip select stay.

The transitions are:
- `ST_IDLE` to `ST_RD_ACC` when a read request is present.
- `ST_IDLE` to `ST_WR_SET` when a write request is present.
- `ST_RD_ACC` to `ST_RD_REC` when its count expires; this is the capture.
- `ST_RD_REC` to `ST_IDLE` when its count expires.
- `ST_WR_SET` to `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` to `ST_WR_HOLD` when its count expires.
- `ST_WR_HOLD` to `ST_IDLE` when its count expires.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, with no request, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_ready` is 0.
- R2: A read request seen in idle starts, on the next cycle, a phase of `ceil(max(T_RC, T_AA, T_OE) / T_CLK)` cycles with a minimum of 1. In this phase `mem_ce_n` = 0, `mem_oe_n` = 0, `mem_we_n` = 1 and `mem_dq_oe` = 0.
- R3: The read byte is sampled from `mem_dq_i` at the clock edge that ends the read phase. It appears on `rsp_rdata` with `rsp_ready` = 1 for exactly one cycle, which is the first cycle after that edge.
- R4: After a read, all strobes stay high and the driver stays off for `ceil(T_OHZ / T_CLK)` cycles (minimum 1) before the machine returns to idle. `mem_dq_oe` only rises once `mem_oe_n` has been high for at least that many cycles.
- R5: A write request seen in idle gives one set-up cycle with `mem_ce_n` = 0, `mem_we_n` = 1 and `mem_dq_oe` = 1. Then `mem_we_n` = 0 for `ceil(max(T_WP, T_AW, T_DS) / T_CLK)` cycles, with chip select low and the driver on.
- R6: After write enable rises, chip select stays low and the data stays driven for `max(1, ceil(T_WC / T_CLK) - pulse - 1)` cycles. The machine then returns to idle with `rsp_ready` = 1 for one cycle, and the memory holds the written byte.
- R7: While `mem_ce_n` = 0, `mem_addr` equals the request address and does not change. While `mem_dq_oe` = 1, `mem_dq_o` equals the request write data and does not change.
- R8: `mem_oe_n` is never 0 while `mem_we_n` = 0 or while `mem_dq_oe` = 1.
- R9: A request is taken only in idle. A request already present at the end of a read waits out the whole recovery phase, then one idle cycle, before its phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 15 | Memory address pins |
| mem_dq_o | output | 8 | Value the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Enable of the controller's data driver |
| mem_dq_i | input | 8 | Data bus as seen by the controller |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The stability checks on address and write data rely on the host holding `req_addr`, `req_wdata` and `req_write` steady from the moment it raises `req_valid` until it sees `rsp_ready`. The bench changes those inputs only on a falling edge, and only while no access is in flight or in the cycle where ready is seen. The checks on turnaround and pulse width also assume that `mem_dq_i` carries real data only as the memory's own access times allow. The bench's memory model therefore returns a junk byte on every cycle before both the chip-select and the output-enable access windows have elapsed.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_REC   = 3'd2,
        ST_WR_SET   = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } ctl_state_t;

    // whole cycles covering a time in ps, never below one
    function automatic int cycles_for(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RD_CYC  = 4,
    parameter int WP_CYC  = 3,
    parameter int WH_CYC  = 1,
    parameter int OHZ_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WH_LOAD  = CNT_W'(WH_CYC - 1);
    localparam logic [CNT_W-1:0] OHZ_LOAD = CNT_W'(OHZ_CYC - 1);

    ctl_state_t state_q, state_d;
    logic       ready_q, ready_d;

    // next state, timer loads and event strobes
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        ready_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SET;
                        tmr_val = '0;
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = RD_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    ready_d  = 1'b1;
                    state_d  = ST_RD_REC;
                    tmr_load = 1'b1;
                    tmr_val  = OHZ_LOAD;
                end
            end
            ST_RD_REC: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SET: begin
                if (tmr_done) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WP_LOAD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = WH_LOAD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                    ready_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= ready_d;
        end
    end

    // pin decode from state
    always_comb begin
        ce_n  = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RD_REC: begin
            end
            ST_RD_ACC: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            ST_WR_SET, ST_WR_HOLD: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign ready = ready_q;

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_dq_i;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rdata    = rdata_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter int T_CLK_PS = 10000,
    parameter int T_RC_PS  = 35000,
    parameter int T_AA_PS  = 35000,
    parameter int T_OE_PS  = 15000,
    parameter int T_WC_PS  = 35000,
    parameter int T_WP_PS  = 20000,
    parameter int T_AW_PS  = 25000,
    parameter int T_DS_PS  = 15000,
    parameter int T_OHZ_PS = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int RD_CYC  = max_of(cycles_for(T_RC_PS, T_CLK_PS),
                             max_of(cycles_for(T_AA_PS, T_CLK_PS),
                                    cycles_for(T_OE_PS, T_CLK_PS)));
    localparam int WP_CYC  = max_of(cycles_for(T_WP_PS, T_CLK_PS),
                             max_of(cycles_for(T_AW_PS, T_CLK_PS),
                                    cycles_for(T_DS_PS, T_CLK_PS)));
    localparam int WC_CYC  = cycles_for(T_WC_PS, T_CLK_PS);
    localparam int WH_CYC  = max_of(1, WC_CYC - WP_CYC - 1);
    localparam int OHZ_CYC = cycles_for(T_OHZ_PS, T_CLK_PS);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .WH_CYC  (WH_CYC),
        .OHZ_CYC (OHZ_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (rsp_ready),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rdata     (rsp_rdata)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int OHZ_CYC = 2,
    parameter int WP_CYC  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_o,
    input logic [ADDR_W-1:0] addr,
    input logic              ready
);

    int oe_hi_cnt;
    int we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_cnt <= OHZ_CYC;
            we_lo_cnt <= 0;
        end else begin
            if (!oe_n)                 oe_hi_cnt <= 0;
            else if (oe_hi_cnt < OHZ_CYC) oe_hi_cnt <= oe_hi_cnt + 1;
            if (!we_n)                 we_lo_cnt <= we_lo_cnt + 1;
            else                       we_lo_cnt <= 0;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |-> (ce_n && oe_n && we_n && !dq_oe && !ready)); // R1
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R3
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n) $rose(dq_oe) |-> (oe_hi_cnt >= OHZ_CYC)); // R4
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (we_lo_cnt >= WP_CYC)); // R5
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (!ce_n && dq_oe)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |=> (ce_n || $stable(addr))); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |=> (!dq_oe || $stable(dq_o))); // R7
    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !we_n)); // R8
    AST_NO_OE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> oe_n); // R8

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OHZ_CYC (OHZ_CYC),
    .WP_CYC  (WP_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (mem_ce_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .dq_oe (mem_dq_oe),
    .dq_o  (mem_dq_o),
    .addr  (mem_addr),
    .ready (rsp_ready)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int CLK_PS  = 10000;
    localparam int P_RC    = 55000;
    localparam int P_AA    = 55000;
    localparam int P_OE    = 25000;
    localparam int P_WC    = 55000;
    localparam int P_WP    = 35000;
    localparam int P_AW    = 40000;
    localparam int P_DS    = 25000;
    localparam int P_OHZ   = 15000;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_PS - 1) / CLK_PS;
        if (c < 1) c = 1;
        return c;
    endfunction

    // expected phase lengths from the requirements
    localparam int E_RD  = 6;   // max(55,55,25) ns at 10 ns
    localparam int E_WP  = 4;   // max(35,40,25) ns
    localparam int E_WH  = 1;   // max(1, 6-4-1)
    localparam int E_OHZ = 2;   // 15 ns
    localparam int M_AA  = 6;   // memory model: chip-select access
    localparam int M_OE  = 3;   // memory model: output-enable access

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_ready;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i = 8'hEE;
    logic        mem_ce_n, mem_oe_n, mem_we_n;

    sram_ctl #(
        .T_CLK_PS (CLK_PS), .T_RC_PS (P_RC), .T_AA_PS (P_AA), .T_OE_PS (P_OE),
        .T_WC_PS  (P_WC),   .T_WP_PS (P_WP), .T_AW_PS (P_AW), .T_DS_PS (P_DS),
        .T_OHZ_PS (P_OHZ)
    ) u_sram_ctl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
        .mem_dq_i (mem_dq_i),
        .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n)
    );

    always #(CLK_PS / 2 * 1ps) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // ---------------- memory model ----------------
    logic [7:0] marr [int];
    int  ce_cnt = 0;
    int  oe_cnt = 0;
    int  oe_hi  = 100;
    logic prev_we = 1'b1;
    logic prev_doe = 1'b0;

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            ce_cnt++;
            oe_cnt++;
        end else begin
            ce_cnt = 0;
            oe_cnt = 0;
        end
        if (ce_cnt >= M_AA && oe_cnt >= M_OE)
            mem_dq_i = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
        else
            mem_dq_i = 8'hEE;
        if (rst_n && !prev_we && mem_we_n && !mem_ce_n && mem_dq_oe)
            marr[int'(mem_addr)] = mem_dq_o;
        if (rst_n && mem_dq_oe && !prev_doe) begin
            n_cmp++;
            if (oe_hi < E_OHZ) begin
                n_bad++;
                $display("FAIL R4 turnaround: oe high %0d cycles, expected >= %0d", oe_hi, E_OHZ);
            end
        end
        if (mem_oe_n) oe_hi++; else oe_hi = 0;
        prev_we  = mem_we_n;
        prev_doe = mem_dq_oe;
    end

    // ---------------- reference model ----------------
    logic [4:0]  exp_q [$];   // {ce_n, oe_n, we_n, dq_oe, ready}
    string       tag_q [$];
    logic [7:0]  ref_mem [int];
    logic [14:0] cur_addr = '0;
    logic [7:0]  cur_wdata = '0;
    logic [7:0]  exp_rdata = '0;
    bit          saw_ready = 1'b0;

    task automatic push(input logic [4:0] v, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic compare();
        logic [4:0] e;
        logic [4:0] a;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = 5'b11100;
            t = "R1";
        end
        a = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ready};
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s pins {ce,oe,we,doe,rdy}: actual %b expected %b", t, a, e);
        end
        if (!mem_ce_n) begin
            n_cmp++;
            if (mem_addr !== cur_addr) begin
                n_bad++;
                $display("FAIL R7 address: actual %h expected %h", mem_addr, cur_addr);
            end
        end
        if (mem_dq_oe) begin
            n_cmp++;
            if (mem_dq_o !== cur_wdata) begin
                n_bad++;
                $display("FAIL R7 write data: actual %h expected %h", mem_dq_o, cur_wdata);
            end
        end
        if (e[0] && rsp_ready && !req_write) begin
            n_cmp++;
            if (rsp_rdata !== exp_rdata) begin
                n_bad++;
                $display("FAIL R3 read byte: actual %h expected %h", rsp_rdata, exp_rdata);
            end
        end
        if (rsp_ready) saw_ready = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    // issue one access; when the queue is busy an idle cycle precedes it (R9)
    task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d);
        if (exp_q.size() > 0) push(5'b11100, "R9", 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) begin
            push(5'b01110, "R5", 1);
            push(5'b01010, "R5", E_WP);
            push(5'b01110, "R6", E_WH);
            push(5'b11101, "R6", 1);
            ref_mem[int'(a)] = d;
        end else begin
            push(5'b00100, "R2", E_RD);
            push(5'b11101, "R3", 1);
            push(5'b11100, "R4", E_OHZ - 1);
        end
        saw_ready = 1'b0;
        while (!saw_ready) step();
        // fields follow the accepted request only after the previous one ends
        cur_addr  = a;
        cur_wdata = d;
        if (!wr) exp_rdata = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() > 0) step();
        step();
    endtask

    // cur_addr must be known before the access starts; set it ahead
    task automatic op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        cur_addr  = a;
        cur_wdata = d;
        if (!wr) exp_rdata = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        access(wr, a, d);
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) step();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) step();

        op(1'b1, 15'h0000, 8'h00); settle();
        op(1'b1, 15'h7FFF, 8'hFF); settle();
        op(1'b1, 15'h1234, 8'hA5); settle();
        op(1'b1, 15'h0155, 8'h5A); settle();
        op(1'b0, 15'h1234, 8'h00); settle();
        op(1'b0, 15'h7FFF, 8'h00); settle();
        op(1'b0, 15'h0000, 8'h00); settle();
        op(1'b0, 15'h0155, 8'h00); settle();
        // overwrite, then read back
        op(1'b1, 15'h1234, 8'h3C); settle();
        op(1'b0, 15'h1234, 8'h00); settle();
        // R9: next request raised the cycle ready is seen, during read recovery
        op(1'b0, 15'h0155, 8'h00);
        op(1'b1, 15'h2222, 8'h81);
        op(1'b0, 15'h2222, 8'h00);
        op(1'b1, 15'h4001, 8'h7E);
        op(1'b0, 15'h4001, 8'h00);
        settle();
        // R6: memory content written by the controller
        foreach (ref_mem[k]) begin
            n_cmp++;
            if (!marr.exists(k) || marr[k] !== ref_mem[k]) begin
                n_bad++;
                $display("FAIL R6 stored byte at %h: actual %h expected %h", k,
                         marr.exists(k) ? marr[k] : 8'hxx, ref_mem[k]);
            end
        end
        repeat (4) step();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule